// File: doc/BRIEF.md
# Cascaded Lookup-Table Logic Cell

This block is one logic cell of a configurable fabric. Two four-input lookup tables, F and G, each read a 16-entry, one-bit table addressed by their own four input pins. A third, smaller table H takes the F and G results together with one extra pin and forms the final result. The cell can therefore realise two independent four-input functions, or a single function of up to nine inputs when the combining table is used. Two capture flip-flops, X and Y, each pick one of four sources by configuration: F, G, H or a dedicated pass-through pin.

The F and G tables are real storage rather than fixed wiring. They are filled as a whole through a parallel configuration load. Two memory modes turn them into user RAM with a synchronous write and an asynchronous read. Single-port mode joins them into one 32x1 memory. Dual-port mode gives one write port and two independent read ports.

Top module: `lutblk_cell`

## Requirements
- R1: While reset is asserted, and after it is released, both tables hold all zeros and `q_x`/`q_y` are 0. Reset is asserted asynchronously. Its release takes effect through a two-stage synchroniser.
- R2: When `cfg_load` is high at a clock edge, the F table takes `cfg_tbl_f` and the G table takes `cfg_tbl_g`. `out_f` is F[`in_f`] and `out_g` is G[`in_g`], both combinationally, where bit n of a table is entry n.
- R3: With `cfg_mode` 0 (logic), 3 (treated as logic) or 2 (dual-port), `out_h` = `cfg_tbl_h`[{`in_h`, `out_g`, `out_f`}]. In that index `in_h` is the most significant bit and `out_f` the least significant bit.
- R4: On a clock edge with `ce` high, each flop loads the source its select names: 0 = `out_f`, 1 = `out_g`, 2 = `out_h`, 3 = its own pin (`dir_x` for X, `dir_y` for Y).
- R5: On a clock edge with `ce` low, `q_x` and `q_y` keep their values.
- R6: In logic mode (`cfg_mode` 0 or 3), `we` has no effect on either table.
- R7: In single-port mode (`cfg_mode` 1), a write with `we` high stores `wdata` at entry `in_f` of F when `in_h` is 0, or of G when `in_h` is 1. The other table is unchanged.
- R8: In single-port mode, `out_h` reads the 32x1 memory at {`in_h`, `in_f`}: F[`in_f`] when `in_h` is 0, and G[`in_f`] when `in_h` is 1.
- R9: In dual-port mode (`cfg_mode` 2), a write stores `wdata` at entry `in_f` of both tables. `out_f` reads entry `in_f` and `out_g` independently reads entry `in_g`.
- R10: A read of the address being written in the same cycle shows the old data until the clock edge, and the new data after it.
- R11: When `cfg_load` and `we` are high in the same cycle, only the configuration load takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Parallel load of the F and G tables |
| cfg_tbl_f | input | 16 | Contents loaded into table F |
| cfg_tbl_g | input | 16 | Contents loaded into table G |
| cfg_tbl_h | input | 8 | Contents of combining table H |
| cfg_mode | input | 2 | 0/3 logic, 1 single-port RAM, 2 dual-port RAM |
| cfg_sel_x | input | 2 | Source select of flop X |
| cfg_sel_y | input | 2 | Source select of flop Y |
| in_f | input | 4 | Address/inputs of table F, write address in RAM modes |
| in_g | input | 4 | Address/inputs of table G |
| in_h | input | 1 | Extra input of table H, bank select in single-port mode |
| dir_x | input | 1 | Pass-through pin for flop X |
| dir_y | input | 1 | Pass-through pin for flop Y |
| ce | input | 1 | Capture enable of both flops |
| we | input | 1 | RAM write enable |
| wdata | input | 1 | RAM write data |
| out_f | output | 1 | Table F result |
| out_g | output | 1 | Table G result |
| out_h | output | 1 | Table H result or single-port read data |
| q_x | output | 1 | Flop X |
| q_y | output | 1 | Flop Y |

## Verification
The write checks assume that the mode, `in_f` and `in_h` hold steady from the write edge until the following cycle. Where they do not, the check is vacuous. The stimulus therefore holds the address for the cycle after a directed write, and random cycles check the model each cycle without relying on the assertions. The assertions also take the configuration pins to be quasi-static. The bench changes tables, mode and selects only between cycles and never mid-cycle. Every check is gated by the synchronised internal reset, so the two release cycles after `rst_n` rises are left idle.

// File: rtl/lutblk_pkg.sv
package lutblk_pkg;
  typedef enum logic [1:0] {
    MODE_LOGIC  = 2'd0,
    MODE_RAM_SP = 2'd1,
    MODE_RAM_DP = 2'd2,
    MODE_SPARE  = 2'd3
  } cell_mode_e;

  typedef enum logic [1:0] {
    CAP_F   = 2'd0,
    CAP_G   = 2'd1,
    CAP_H   = 2'd2,
    CAP_PIN = 2'd3
  } cap_src_e;

  localparam int unsigned CAP_SRCS = 4;
endpackage

// File: rtl/lutblk_rst_sync.sv
module lutblk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/lutblk_lut_store.sv
// One table of the cell: parallel load, one synchronous write port,
// NRD asynchronous read ports.
module lutblk_lut_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NRD    = 1,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [DEPTH-1:0]       load_bits,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic                   wr_bit,
  input  logic [NRD*ADDR_W-1:0]  rd_addr,
  output logic [NRD-1:0]         rd_bit
);
  logic [DEPTH-1:0] mem_q;
  logic [DEPTH-1:0] mem_d;
  logic             mem_en;

  // Load takes precedence over a user write.
  always_comb begin
    mem_d  = mem_q;
    mem_en = load | wr_en;
    if (load) begin
      mem_d = load_bits;
    end else if (wr_en) begin
      mem_d[wr_addr] = wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_bit[p] = mem_q[rd_addr[p*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/lutblk_cap_ff.sv
// Capture flop with a configuration-selected source.
module lutblk_cap_ff
  import lutblk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic [1:0]          src_sel,
  input  logic [CAP_SRCS-1:0] cand,
  output logic                q
);
  logic pick;
  logic q_d;

  always_comb begin
    unique case (cap_src_e'(src_sel))
      CAP_F:   pick = cand[CAP_F];
      CAP_G:   pick = cand[CAP_G];
      CAP_H:   pick = cand[CAP_H];
      default: pick = cand[CAP_PIN];
    endcase
    q_d = ce ? pick : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/lutblk_cell.sv
module lutblk_cell
  import lutblk_pkg::*;
#(
  parameter int unsigned LUT_K   = 4,
  parameter int unsigned H_EXTRA = 1,
  localparam int unsigned LUT_N  = 1 << LUT_K,
  localparam int unsigned H_K    = 2 + H_EXTRA,
  localparam int unsigned H_N    = 1 << H_K
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [LUT_N-1:0]   cfg_tbl_f,
  input  logic [LUT_N-1:0]   cfg_tbl_g,
  input  logic [H_N-1:0]     cfg_tbl_h,
  input  logic [1:0]         cfg_mode,
  input  logic [1:0]         cfg_sel_x,
  input  logic [1:0]         cfg_sel_y,
  input  logic [LUT_K-1:0]   in_f,
  input  logic [LUT_K-1:0]   in_g,
  input  logic [H_EXTRA-1:0] in_h,
  input  logic               dir_x,
  input  logic               dir_y,
  input  logic               ce,
  input  logic               we,
  input  logic               wdata,
  output logic               out_f,
  output logic               out_g,
  output logic               out_h,
  output logic               q_x,
  output logic               q_y
);
  logic       rst_q_n;
  cell_mode_e mode;
  logic       is_sp, is_dp, wr_ok;
  logic       f_we, g_we;
  logic       f_rd;
  logic [1:0] g_rd;
  logic       h_lut;
  logic       sp_rd;

  lutblk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  always_comb begin
    mode  = cell_mode_e'(cfg_mode);
    is_sp = (mode == MODE_RAM_SP);
    is_dp = (mode == MODE_RAM_DP);
    wr_ok = we & (is_sp | is_dp);
    f_we  = wr_ok & (is_dp | ~in_h[0]);
    g_we  = wr_ok & (is_dp |  in_h[0]);
  end

  lutblk_lut_store #(.ADDR_W(LUT_K), .NRD(1)) u_tbl_f (
    .clk(clk), .rst_n(rst_q_n), .load(cfg_load), .load_bits(cfg_tbl_f),
    .wr_en(f_we), .wr_addr(in_f), .wr_bit(wdata),
    .rd_addr(in_f), .rd_bit(f_rd)
  );

  // Second read port of G serves the upper half of the 32x1 memory.
  lutblk_lut_store #(.ADDR_W(LUT_K), .NRD(2)) u_tbl_g (
    .clk(clk), .rst_n(rst_q_n), .load(cfg_load), .load_bits(cfg_tbl_g),
    .wr_en(g_we), .wr_addr(in_f), .wr_bit(wdata),
    .rd_addr({in_f, in_g}), .rd_bit(g_rd)
  );

  always_comb begin
    h_lut = cfg_tbl_h[{in_h, g_rd[0], f_rd}];
    sp_rd = in_h[0] ? g_rd[1] : f_rd;
    out_f = f_rd;
    out_g = g_rd[0];
    out_h = is_sp ? sp_rd : h_lut;
  end

  logic [1:0]          sel_arr  [2];
  logic                pin_arr  [2];
  logic [1:0]          q_arr;

  assign sel_arr[0] = cfg_sel_x;
  assign sel_arr[1] = cfg_sel_y;
  assign pin_arr[0] = dir_x;
  assign pin_arr[1] = dir_y;

  for (genvar i = 0; i < 2; i++) begin : g_cap
    logic [CAP_SRCS-1:0] cand;
    always_comb begin
      cand          = '0;
      cand[CAP_F]   = out_f;
      cand[CAP_G]   = out_g;
      cand[CAP_H]   = out_h;
      cand[CAP_PIN] = pin_arr[i];
    end
    lutblk_cap_ff u_ff (
      .clk(clk), .rst_n(rst_q_n), .ce(ce),
      .src_sel(sel_arr[i]), .cand(cand), .q(q_arr[i])
    );
  end

  assign q_x = q_arr[0];
  assign q_y = q_arr[1];
endmodule

// File: rtl/lutblk_cell_chk.sv
module lutblk_cell_chk #(
  parameter int unsigned LUT_K   = 4,
  parameter int unsigned H_EXTRA = 1
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               cfg_load,
  input logic [1:0]         cfg_mode,
  input logic [1:0]         cfg_sel_x,
  input logic               ce,
  input logic               we,
  input logic               wdata,
  input logic [LUT_K-1:0]   in_f,
  input logic [H_EXTRA-1:0] in_h,
  input logic               dir_x,
  input logic               out_f,
  input logic               out_h,
  input logic               q_x,
  input logic               q_y
);
  // R5: no capture enable, both flops keep their value
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ce |=> ($stable(q_x) && $stable(q_y)));

  // R4: pass-through pin source
  a_r4_pin_capture: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ce && cfg_sel_x == 2'd3) |=> (q_x == $past(dir_x)));

  // R4: combining-table source
  a_r4_h_capture: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ce && cfg_sel_x == 2'd2) |=> (q_x == $past(out_h)));

  // R6: logic mode leaves table F untouched
  a_r6_logic_no_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((cfg_mode == 2'd0 || cfg_mode == 2'd3) && !cfg_load)
      |=> (!$stable(in_f) || $stable(out_f)));

  // R9: dual-port write is seen on read port A at the same address
  a_r9_dp_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_mode == 2'd2 && we && !cfg_load)
      |=> (in_f != $past(in_f) || out_f == $past(wdata)));

  // R7: single-port write is read back through the 32x1 view
  a_r7_sp_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_mode == 2'd1 && we && !cfg_load)
      |=> (cfg_mode != 2'd1 || in_f != $past(in_f) || in_h != $past(in_h)
           || out_h == $past(wdata)));
endmodule

bind lutblk_cell lutblk_cell_chk #(.LUT_K(LUT_K), .H_EXTRA(H_EXTRA)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
  .cfg_sel_x(cfg_sel_x), .ce(ce), .we(we), .wdata(wdata), .in_f(in_f),
  .in_h(in_h), .dir_x(dir_x), .out_f(out_f), .out_h(out_h),
  .q_x(q_x), .q_y(q_y)
);

// File: tb/lutblk_cell_test.sv
module lutblk_cell_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [15:0] cfg_tbl_f, cfg_tbl_g;
  logic [7:0]  cfg_tbl_h;
  logic [1:0]  cfg_mode, cfg_sel_x, cfg_sel_y;
  logic [3:0]  in_f, in_g;
  logic [0:0]  in_h;
  logic        dir_x, dir_y, ce, we, wdata;
  logic        out_f, out_g, out_h, q_x, q_y;

  int unsigned total = 0;
  int unsigned bad   = 0;
  bit          done  = 1'b0;

  logic [15:0] m_f, m_g;
  logic        m_qx, m_qy;

  always #2 clk = ~clk;

  lutblk_cell uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_tbl_f(cfg_tbl_f),
    .cfg_tbl_g(cfg_tbl_g), .cfg_tbl_h(cfg_tbl_h), .cfg_mode(cfg_mode),
    .cfg_sel_x(cfg_sel_x), .cfg_sel_y(cfg_sel_y), .in_f(in_f), .in_g(in_g),
    .in_h(in_h), .dir_x(dir_x), .dir_y(dir_y), .ce(ce), .we(we),
    .wdata(wdata), .out_f(out_f), .out_g(out_g), .out_h(out_h),
    .q_x(q_x), .q_y(q_y)
  );

  function automatic logic exp_h(logic [1:0] md, logic [15:0] tf,
                                 logic [15:0] tg, logic [7:0] th,
                                 logic [3:0] af, logic [3:0] ag, logic hh);
    if (md == 2'd1) return hh ? tg[af] : tf[af];
    return th[{hh, tg[ag], tf[af]}];
  endfunction

  function automatic logic exp_src(logic [1:0] s, logic f, logic g,
                                   logic h, logic pin);
    case (s)
      2'd0: return f;
      2'd1: return g;
      2'd2: return h;
      default: return pin;
    endcase
  endfunction

  task automatic chk(string tag, string name, logic got, logic expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s %s got=%b exp=%b t=%0t", tag, name, got, expv, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Inputs are set after a falling edge; checks run 1 ns later, before
  // the rising edge; the model is then advanced with the same inputs.
  task automatic run_cycle(string tag);
    logic ef, eg, eh;
    #1;
    ef = m_f[in_f];
    eg = m_g[in_g];
    eh = exp_h(cfg_mode, m_f, m_g, cfg_tbl_h, in_f, in_g, in_h[0]);
    chk(tag, "out_f", out_f, ef);
    chk(tag, "out_g", out_g, eg);
    chk(tag, "out_h", out_h, eh);
    chk(tag, "q_x", q_x, m_qx);
    chk(tag, "q_y", q_y, m_qy);
    @(posedge clk);
    if (ce) begin
      m_qx = exp_src(cfg_sel_x, ef, eg, eh, dir_x);
      m_qy = exp_src(cfg_sel_y, ef, eg, eh, dir_y);
    end
    if (cfg_load) begin
      m_f = cfg_tbl_f;
      m_g = cfg_tbl_g;
    end else if (we && cfg_mode == 2'd1) begin
      if (in_h[0]) m_g[in_f] = wdata;
      else         m_f[in_f] = wdata;
    end else if (we && cfg_mode == 2'd2) begin
      m_f[in_f] = wdata;
      m_g[in_f] = wdata;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_load = 1'b0; ce = 1'b0; we = 1'b0; wdata = 1'b0;
    dir_x = 1'b0; dir_y = 1'b0; in_f = '0; in_g = '0; in_h = '0;
  endtask

  task automatic rand_pins();
    in_f  = 4'($urandom);
    in_g  = 4'($urandom);
    in_h  = 1'($urandom);
    dir_x = 1'($urandom);
    dir_y = 1'($urandom);
    wdata = 1'($urandom);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    idle();
    cfg_tbl_f = '0; cfg_tbl_g = '0; cfg_tbl_h = '0;
    cfg_mode = 2'd0; cfg_sel_x = 2'd0; cfg_sel_y = 2'd0;
    m_f = '0; m_g = '0; m_qx = 1'b0; m_qy = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "q_x", q_x, 1'b0);
    chk("R1", "q_y", q_y, 1'b0);
    chk("R1", "out_f", out_f, 1'b0);
    rst_n = 1'b1;
    repeat (3) run_cycle("R1");

    // R2: configuration load
    cfg_tbl_f = 16'($urandom); cfg_tbl_g = 16'($urandom);
    cfg_tbl_h = 8'($urandom);
    cfg_load = 1'b1;
    run_cycle("R2");
    cfg_load = 1'b0;

    // R2, R3, R6: logic mode, random inputs, writes must be ignored
    for (int i = 0; i < 60; i++) begin
      rand_pins();
      cfg_mode = (i % 2 == 0) ? 2'd0 : 2'd3;
      we = 1'($urandom);
      run_cycle(we ? "R6" : "R3");
    end
    we = 1'b0;

    // R4: every source for both flops
    for (int s = 0; s < 4; s++) begin
      cfg_sel_x = 2'(s);
      cfg_sel_y = 2'(3 - s);
      for (int i = 0; i < 12; i++) begin
        rand_pins();
        ce = 1'b1;
        run_cycle("R4");
      end
    end

    // R5: capture disabled
    for (int i = 0; i < 12; i++) begin
      rand_pins();
      ce = 1'b0;
      cfg_sel_x = 2'($urandom);
      cfg_sel_y = 2'($urandom);
      run_cycle("R5");
    end

    // R7, R8: single-port mode, fill all 32 entries then read them back
    cfg_mode = 2'd1;
    for (int a = 0; a < 32; a++) begin
      rand_pins();
      in_f = 4'(a); in_h = 1'(a >> 4);
      we = 1'b1;
      run_cycle("R7");
      we = 1'b0;
      run_cycle("R8");
    end
    for (int a = 0; a < 32; a++) begin
      in_f = 4'(a); in_h = 1'(a >> 4); in_g = 4'($urandom);
      run_cycle("R8");
    end

    // R9: dual-port mode, independent read port
    cfg_mode = 2'd2;
    for (int i = 0; i < 40; i++) begin
      rand_pins();
      we = 1'($urandom);
      run_cycle("R9");
    end

    // R10: read of the address under write shows old then new data
    in_f = 4'd5; in_g = 4'd5; we = 1'b1; wdata = ~m_f[5];
    run_cycle("R10");
    we = 1'b0;
    run_cycle("R10");
    cfg_mode = 2'd1; in_h = 1'b1; in_f = 4'd9; we = 1'b1; wdata = ~m_g[9];
    run_cycle("R10");
    we = 1'b0;
    run_cycle("R10");

    // R11: load wins over a simultaneous write
    cfg_mode = 2'd2;
    cfg_tbl_f = 16'hA5C3; cfg_tbl_g = 16'h3C5A;
    in_f = 4'd0; wdata = ~cfg_tbl_f[0]; we = 1'b1; cfg_load = 1'b1;
    run_cycle("R11");
    we = 1'b0; cfg_load = 1'b0; in_g = 4'd0;
    run_cycle("R11");

    // R4 and R9: mixed random traffic over all modes
    for (int i = 0; i < 300; i++) begin
      rand_pins();
      cfg_mode  = 2'($urandom);
      cfg_sel_x = 2'($urandom);
      cfg_sel_y = 2'($urandom);
      ce = 1'($urandom);
      we = 1'($urandom);
      cfg_load = ($urandom % 20) == 0;
      if (cfg_load) begin
        cfg_tbl_f = 16'($urandom);
        cfg_tbl_g = 16'($urandom);
      end
      run_cycle("R4");
    end
    idle();
    run_cycle("R5");
    finish_run();
  end
endmodule